// File: doc/BRIEF.md
# Segmented Hamming Distance Engine

This block measures how many bit positions differ between two wide operands, 512 bits by default. When a start is accepted, the two operands are XORed and the difference vector is stored. The vector is padded with zeros up to a whole number of table groups. It is then fed, one segment per clock, through a bank of small population-count lookup tables. Each table is addressed by 3 or 4 difference bits. Its entries are computed at elaboration and inferred as constant ROM.

The per-table partial counts of a segment are added and registered. The registered segment sums are then added into an accumulator, so the table bank only needs to be as wide as one segment, not the whole vector. A caller pulses the start input together with both operands. The block raises busy while it works. It pulses done for one cycle, and the distance output holds the result until the next accepted start.

Top module: `hd_engine`

## Requirements
- R1: When done is high, the distance output equals the number of set bits in the XOR of the two operands sampled with the accepted start.
- R2: Done goes high exactly SEGMENTS+1 clock cycles after the clock edge that accepts a start, and stays high for one cycle only.
- R3: A start that arrives while busy is high is ignored. The stored operands, the result and the timing of the running operation do not change.
- R4: An accepted start clears the accumulator, so a result never includes counts from an earlier operation.
- R5: The distance output is clog2(WIDTH+1) bits wide, so a distance equal to WIDTH, with every bit different, is reported exactly.
- R6: When WIDTH is not a multiple of the table group size, the missing high bits are treated as zeros and add nothing to the distance.
- R7: The table address width may be 3 or 4, and both settings give the same distance for the same operands.
- R8: Busy is high from the cycle after an accepted start until done is high. Busy and done are never high together.
- R9: After reset, busy and done are low and the distance output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a new distance; accepted only while busy_o is low |
| opa_i | input | WIDTH | First operand, sampled on the accepting edge |
| opb_i | input | WIDTH | Second operand, sampled on the accepting edge |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: dist_o holds the final distance |
| dist_o | output | clog2(WIDTH+1) | Hamming distance; holds its value until the next accepted start |

## Verification
On every cycle the assertions check the following:
- done is a single pulse and arrives at the fixed latency, counted from the accepting edge.
- done and busy never overlap.
- the accumulator is zero right after an accepted start.
- the stored difference vector does not change when a start arrives during busy.
- neither a segment sum nor the distance ever exceeds its largest legal value.

Only the bench scenarios can show that the numbers are correct. They compare the distance against an independent bit count for every operand pattern. They also cover:
- zero padding in a 10-bit configuration with 3-bit tables.
- the full-width distance of 512 in the default configuration.
- that a start during busy leaves the first operands' result in place.

// File: rtl/hd_pkg.sv
package hd_pkg;

  // Lookup table image: up to 16 entries, each a 3-bit count (max 4 ones)
  typedef logic [15:0][2:0] lut_rom_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // Table contents: entry e holds the number of ones in the low aw bits of e
  function automatic lut_rom_t build_rom(input int aw);
    lut_rom_t r;
    r = '0;
    for (int e = 0; e < (1 << aw); e++) begin
      int c;
      c = 0;
      for (int k = 0; k < aw; k++) c += (e >> k) & 1;
      r[e] = 3'(c);
    end
    return r;
  endfunction

endpackage

// File: rtl/hd_lut_bank.sv
module hd_lut_bank
  import hd_pkg::*;
#(
  parameter int AW     = 4,
  parameter int GROUPS = 32,
  localparam int SEGP  = GROUPS * AW
) (
  input  logic [SEGP-1:0]         seg_i,
  output logic [GROUPS-1:0][2:0]  cnt_o
);

  localparam lut_rom_t ROM = build_rom(AW);

  for (genvar g = 0; g < GROUPS; g++) begin : g_tab
    logic [3:0] addr;
    always_comb begin
      addr     = 4'(seg_i[g*AW +: AW]);
      cnt_o[g] = ROM[addr];
    end
  end

endmodule

// File: rtl/hd_sum_tree.sv
module hd_sum_tree #(
  parameter int GROUPS = 32,
  parameter int SW     = 8
) (
  input  logic [GROUPS-1:0][2:0] cnt_i,
  output logic [SW-1:0]          sum_o
);

  // Pairwise reduction: level widths halve, rounded up
  localparam int LEVELS = (GROUPS > 1) ? $clog2(GROUPS) : 0;

  logic [LEVELS:0][GROUPS-1:0][SW-1:0] lvl;

  for (genvar g = 0; g < GROUPS; g++) begin : g_in
    assign lvl[0][g] = SW'(cnt_i[g]);
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int NIN  = hd_pkg::ceil_div(GROUPS, 1 << l);
    localparam int NOUT = hd_pkg::ceil_div(NIN, 2);
    for (genvar n = 0; n < GROUPS; n++) begin : g_node
      if (n < NOUT && 2*n+1 < NIN) begin : g_add
        assign lvl[l+1][n] = lvl[l][2*n] + lvl[l][2*n+1];
      end else if (n < NOUT) begin : g_pass
        assign lvl[l+1][n] = lvl[l][2*n];
      end else begin : g_zero
        assign lvl[l+1][n] = '0;
      end
    end
  end

  assign sum_o = lvl[LEVELS][0];

endmodule

// File: rtl/hd_ctrl.sv
module hd_ctrl #(
  parameter int SEGMENTS = 4,
  localparam int SIDX_W  = (SEGMENTS > 1) ? $clog2(SEGMENTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              feed_o,
  output logic [SIDX_W-1:0] seg_idx_o,
  output logic              pv_o,
  output logic              done_o
);

  localparam logic [SIDX_W-1:0] LAST = SIDX_W'(SEGMENTS - 1);

  logic pv_last;
  logic feed_last;

  assign accept_o  = start_i && !busy_o;
  assign feed_last = feed_o && (seg_idx_o == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o    <= 1'b0;
      feed_o    <= 1'b0;
      seg_idx_o <= '0;
      pv_o      <= 1'b0;
      pv_last   <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      pv_o    <= feed_o;
      pv_last <= feed_last;
      done_o  <= pv_o && pv_last;
      if (accept_o) begin
        busy_o    <= 1'b1;
        feed_o    <= 1'b1;
        seg_idx_o <= '0;
      end else begin
        if (pv_o && pv_last) busy_o <= 1'b0;
        if (feed_last)       feed_o <= 1'b0;
        if (feed_o && !feed_last) seg_idx_o <= seg_idx_o + 1'b1;
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

// File: rtl/hd_engine.sv
module hd_engine
  import hd_pkg::*;
#(
  parameter int WIDTH    = 512,
  parameter int LUT_AW   = 4,
  parameter int SEGMENTS = 4,
  localparam int DW      = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DW-1:0]    dist_o
);

  localparam int SEG_W  = ceil_div(WIDTH, SEGMENTS);
  localparam int GROUPS = ceil_div(SEG_W, LUT_AW);
  localparam int SEGP   = GROUPS * LUT_AW;
  localparam int PAD_W  = SEGMENTS * SEGP;
  localparam int PSW    = $clog2(SEGP + 1);
  localparam int SIDX_W = (SEGMENTS > 1) ? $clog2(SEGMENTS) : 1;
  localparam int LAT    = SEGMENTS + 1;
  localparam int LCW    = $clog2(LAT + 2);

  logic              accept;
  logic              feed;
  logic              pv;
  logic [SIDX_W-1:0] seg_idx;
  logic [PAD_W-1:0]  diff_q;
  logic [SEGP-1:0]   seg;
  logic [GROUPS-1:0][2:0] cnt;
  logic [PSW-1:0]    seg_sum;
  logic [PSW-1:0]    psum_q;
  logic [DW-1:0]     acc_q;

  hd_ctrl #(.SEGMENTS(SEGMENTS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .accept_o  (accept),
    .busy_o    (busy_o),
    .feed_o    (feed),
    .seg_idx_o (seg_idx),
    .pv_o      (pv),
    .done_o    (done_o)
  );

  // Difference vector, zero padded above WIDTH (R6)
  always_ff @(posedge clk) begin
    if (!rst_n)      diff_q <= '0;
    else if (accept) diff_q <= PAD_W'(opa_i ^ opb_i);
  end

  assign seg = diff_q[int'(seg_idx)*SEGP +: SEGP];

  hd_lut_bank #(.AW(LUT_AW), .GROUPS(GROUPS)) u_bank (
    .seg_i (seg),
    .cnt_o (cnt)
  );

  hd_sum_tree #(.GROUPS(GROUPS), .SW(PSW)) u_tree (
    .cnt_i (cnt),
    .sum_o (seg_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psum_q <= '0;
      acc_q  <= '0;
    end else begin
      if (feed) psum_q <= seg_sum;
      if (accept)  acc_q <= '0;
      else if (pv) acc_q <= acc_q + DW'(psum_q);
    end
  end

  assign dist_o = acc_q;

  // Cycles since the accepting edge, for the latency check
  logic [LCW-1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)      lat_cnt <= '0;
    else if (accept) lat_cnt <= '0;
    else if (busy_o) lat_cnt <= lat_cnt + 1'b1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat_cnt == LCW'(LAT)));

  // R4
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_o && dist_o == '0));

  // R3
  ignore_busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> $stable(diff_q));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dist_o <= DW'(WIDTH));

  // R1
  seg_sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psum_q <= PSW'(SEGP));

endmodule

// File: tb/hd_engine_tb.sv
module hd_engine_tb;

  localparam int SW_W = 10;
  localparam int SW_S = 2;
  localparam int SW_L = SW_S + 1;
  localparam int WW   = 512;
  localparam int WS   = 4;
  localparam int WL   = WS + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            s_start = 1'b0;
  logic [SW_W-1:0] s_a = '0, s_b = '0;
  logic            s_busy, s_done;
  logic [3:0]      s_dist;

  logic            w_start = 1'b0;
  logic [WW-1:0]   w_a = '0, w_b = '0;
  logic            w_busy, w_done;
  logic [9:0]      w_dist;

  hd_engine #(.WIDTH(SW_W), .LUT_AW(3), .SEGMENTS(SW_S)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(s_start), .opa_i(s_a), .opb_i(s_b),
    .busy_o(s_busy), .done_o(s_done), .dist_o(s_dist));

  hd_engine u_dut_wide (
    .clk(clk), .rst_n(rst_n), .start_i(w_start), .opa_i(w_a), .opb_i(w_b),
    .busy_o(w_busy), .done_o(w_done), .dist_o(w_dist));

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Small configuration; poke=1 drives a second start while busy (R3)
  task automatic run_small(input logic [SW_W-1:0] a, input logic [SW_W-1:0] b,
                           input bit poke);
    int exp;
    exp = $countones(a ^ b);
    @(negedge clk); s_a = a; s_b = b; s_start = 1'b1;
    @(negedge clk);
    if (poke) begin s_a = ~a; s_b = b; end
    else s_start = 1'b0;
    for (int j = 0; j < SW_L; j++) begin
      if (s_done || !s_busy) chk(1'b0, "R2/R8 early done or busy low", int'(s_done), 0);
      @(negedge clk);
      s_start = 1'b0;
    end
    chk(s_done === 1'b1, "R2 done at latency", int'(s_done), 1);
    chk(s_busy === 1'b0, "R8 busy low with done", int'(s_busy), 0);
    chk(int'(s_dist) == exp, poke ? "R3 busy start ignored" : "R1/R6 small distance",
        int'(s_dist), exp);
    @(negedge clk);
    chk(s_done === 1'b0, "R2 done single pulse", int'(s_done), 0);
    chk(int'(s_dist) == exp, "R1 distance held", int'(s_dist), exp);
  endtask

  task automatic run_wide(input logic [WW-1:0] a, input logic [WW-1:0] b, input string req);
    int exp;
    exp = $countones(a ^ b);
    @(negedge clk); w_a = a; w_b = b; w_start = 1'b1;
    @(negedge clk); w_start = 1'b0;
    for (int j = 0; j < WL; j++) begin
      if (w_done || !w_busy) chk(1'b0, "R2/R8 wide early done", int'(w_done), 0);
      @(negedge clk);
    end
    chk(w_done === 1'b1, "R2 wide done at latency", int'(w_done), 1);
    chk(int'(w_dist) == exp, req, int'(w_dist), exp);
  endtask

  initial begin : watchdog
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(1'b0, "watchdog expired", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : main
    logic [WW-1:0] ra, rb;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(s_busy === 1'b0 && s_done === 1'b0, "R9 small reset flags", int'(s_busy), 0);
    chk(s_dist === '0, "R9 small reset dist", int'(s_dist), 0);
    chk(w_busy === 1'b0 && w_done === 1'b0 && w_dist === '0, "R9 wide reset", int'(w_dist), 0);
    rst_n = 1'b1;

    // R1 R6: sweep of all first operands against a derived second operand
    for (int a = 0; a < 1024; a++) begin
      logic [SW_W-1:0] av, bv;
      av = SW_W'(a);
      bv = {av[4:0], av[9:5]} ^ 10'h155;
      run_small(av, bv, 1'b0);
    end
    // R5 all bits differ, R4 then zero distance after a large one
    run_small('1, '0, 1'b0);
    run_small(10'h2A5, 10'h2A5, 1'b0);
    // R6: only the top bits, which share a segment with the padding
    run_small(10'h300, 10'h000, 1'b0);
    // R3 start while busy ignored
    run_small(10'h00F, 10'h000, 1'b1);
    run_small(10'h3FF, 10'h001, 1'b1);

    // R7 default 4-bit tables on the wide configuration
    run_wide('0, '0, "R7 wide zero");
    run_wide('1, '0, "R5 wide full distance");
    run_wide('0, '0, "R4 wide cleared after full");
    for (int k = 0; k < WW; k += 37) begin
      logic [WW-1:0] one;
      one = '0; one[k] = 1'b1;
      run_wide(one, '0, "R7 wide walking bit");
    end
    for (int t = 0; t < 40; t++) begin
      for (int w = 0; w < WW/32; w++) begin
        ra[w*32 +: 32] = $urandom;
        rb[w*32 +: 32] = $urandom;
      end
      run_wide(ra, rb, "R1 wide random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule